// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block joins two 8-bit bidirectional buses, called side A and side B. Each side has its own storage register. The register is loaded from that side's resolved bus on a clock edge in which the side's capture strobe is high. For each direction a select picks what the opposite side receives: the live value of the bus, or the value held in the register. Two drive controls set which sides the block drives. The control that drives side B is active high. The control that drives side A is active low. With both sides released, the block isolates the buses, and the registers still capture.

Each side is presented as three signals: the resolved bus value coming in, the value the block wants to drive, and a drive-enable flag. Wired resolution between drivers is done outside the block. A register therefore always stores what is actually on its bus, including a value the block itself is driving.

When both sides are driven and both selects are live, the two buses would form a loop through the block. A keeper register emulates that loop without a combinational path:
- With no outside driver present, both buses hold their last value.
- When an outside driver appears on one side, the block releases that side.
- The other side then follows the outside driver at once.
- The keeper retains that value after the outside driver goes away.

Top module: `regbus_xcvr`

## Requirements
- R1: A synchronous active-high `rst` clears both storage registers to 8'h00. After reset, both stored paths present 8'h00.
- R2: On a rising `clk` edge with `a_cap` high, the A register loads `a_bus_i`. With `b_cap` high, the B register loads `b_bus_i`. The new value appears on the stored paths after that edge.
- R3: Capture happens whatever the drive controls and selects are set to, including while both sides are isolated.
- R4: `b_bus_oe` equals `ab_drive`. When `ab_use_reg` is 0 (live), `b_bus_o` follows `a_bus_i` with no cycle delay. When `ab_use_reg` is 1 (stored), `b_bus_o` shows the A register.
- R5: `a_bus_oe` equals the inverse of `ba_drive_n`. When `ba_use_reg` is 0 (live), `a_bus_o` follows `b_bus_i`. When it is 1 (stored), `a_bus_o` shows the B register.
- R6: With `ab_drive`=0 and `ba_drive_n`=1, neither drive-enable is set.
- R7: With `ab_drive`=1, `ba_drive_n`=0 and both selects at 1, both sides are driven at once. Side A carries the B register and side B carries the A register.
- R8: A register that captures while the block drives its side stores the driven value. For example, live A to B with both strobes high loads the A bus value into both registers.
- R9: Hold mode is `ab_drive`=1, `ba_drive_n`=0 and both selects 0. In hold mode with no outside driver, both sides are driven with the keeper value. That value is the A bus value sampled on the last edge before hold mode was entered, or the last outside value taken during hold mode. It stays unchanged from cycle to cycle.
- R10: In hold mode an outside driver on one side (`a_ext_i` or `b_ext_i` high) clears that side's drive-enable. The other side shows the outside value in the same cycle. The keeper keeps that value after the outside driver is released.
- R11: A register whose strobe is low on an edge keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for registers and keeper |
| rst | input | 1 | Synchronous active-high reset |
| a_cap | input | 1 | Capture strobe for the A register |
| b_cap | input | 1 | Capture strobe for the B register |
| ab_drive | input | 1 | Active-high enable to drive side B |
| ba_drive_n | input | 1 | Active-low enable to drive side A |
| ab_use_reg | input | 1 | Side B source: 0 live A bus, 1 A register |
| ba_use_reg | input | 1 | Side A source: 0 live B bus, 1 B register |
| a_bus_i | input | 8 | Resolved value of bus A |
| a_ext_i | input | 1 | An outside driver is active on bus A |
| a_bus_o | output | 8 | Value the block drives on bus A |
| a_bus_oe | output | 1 | Block drives bus A |
| b_bus_i | input | 8 | Resolved value of bus B |
| b_ext_i | input | 1 | An outside driver is active on bus B |
| b_bus_o | output | 8 | Value the block drives on bus B |
| b_bus_oe | output | 1 | Block drives bus B |

## Verification
Drive-enables, live paths and stored-path selection are combinational. The bench changes inputs on the falling edge and samples one time unit later, in the same cycle. A capture or keeper load takes effect on the next rising edge. The bench therefore steps one full clock (rising then falling edge) before it samples a stored path or a held bus. Register contents are observed only through the stored paths at the ports, after switching to a mode that exposes them.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;

    parameter int unsigned XCVR_W = 8;

    typedef enum logic {
        SRC_LIVE   = 1'b0,
        SRC_STORED = 1'b1
    } src_e;

    typedef struct packed {
        logic drive_a;
        logic drive_b;
        logic hold_loop;
    } drive_t;

    function automatic drive_t decode_drive(input logic ab_en, input logic ba_en_n,
                                            input src_e ab_src, input src_e ba_src);
        drive_t d;
        d.drive_a   = ~ba_en_n;
        d.drive_b   = ab_en;
        d.hold_loop = ab_en && !ba_en_n && (ab_src == SRC_LIVE) && (ba_src == SRC_LIVE);
        return d;
    endfunction

endpackage

// File: rtl/xcvr_capture_reg.sv
module xcvr_capture_reg #(
    parameter int unsigned W = xcvr_pkg::XCVR_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         cap,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst)      q <= '0;
        else if (cap) q <= d;
    end

    // R2
    cap_load_chk: assert property (@(posedge clk) disable iff (rst)
        cap |=> (q === $past(d)));

    // R11
    no_cap_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !cap |=> (q === $past(q)));
endmodule

// File: rtl/xcvr_dir_mux.sv
module xcvr_dir_mux #(
    parameter int unsigned W = xcvr_pkg::XCVR_W
) (
    input  xcvr_pkg::src_e sel,
    input  logic [W-1:0]   live,
    input  logic [W-1:0]   stored,
    output logic [W-1:0]   y
);
    always_comb begin
        case (sel)
            xcvr_pkg::SRC_STORED: y = stored;
            default:              y = live;
        endcase
    end
endmodule

// File: rtl/xcvr_bus_keeper.sv
module xcvr_bus_keeper #(
    parameter int unsigned W = xcvr_pkg::XCVR_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         hold,
    input  logic [W-1:0] a_bus,
    input  logic         a_ext,
    input  logic [W-1:0] b_bus,
    input  logic         b_ext,
    output logic [W-1:0] hold_val
);
    logic [W-1:0] keep_q;
    logic [W-1:0] keep_d;

    always_comb begin
        if (a_ext)      hold_val = a_bus;
        else if (b_ext) hold_val = b_bus;
        else            hold_val = keep_q;
    end

    always_comb begin
        if (!hold) keep_d = a_bus;
        else       keep_d = hold_val;
    end

    always_ff @(posedge clk) begin
        if (rst) keep_q <= '0;
        else     keep_q <= keep_d;
    end

    // R9
    keeper_steady_chk: assert property (@(posedge clk) disable iff (rst)
        (hold && !a_ext && !b_ext) |=> (keep_q === $past(keep_q)));
endmodule

// File: rtl/regbus_xcvr.sv
module regbus_xcvr #(
    parameter int unsigned DATA_W = xcvr_pkg::XCVR_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              a_cap,
    input  logic              b_cap,
    input  logic              ab_drive,
    input  logic              ba_drive_n,
    input  logic              ab_use_reg,
    input  logic              ba_use_reg,
    input  logic [DATA_W-1:0] a_bus_i,
    input  logic              a_ext_i,
    output logic [DATA_W-1:0] a_bus_o,
    output logic              a_bus_oe,
    input  logic [DATA_W-1:0] b_bus_i,
    input  logic              b_ext_i,
    output logic [DATA_W-1:0] b_bus_o,
    output logic              b_bus_oe
);
    import xcvr_pkg::*;

    src_e             ab_src, ba_src;
    drive_t           drv;
    logic [DATA_W-1:0] reg_a, reg_b;
    logic [DATA_W-1:0] to_b, to_a;
    logic [DATA_W-1:0] hold_val;

    assign ab_src = src_e'(ab_use_reg);
    assign ba_src = src_e'(ba_use_reg);
    assign drv    = decode_drive(ab_drive, ba_drive_n, ab_src, ba_src);

    xcvr_capture_reg #(.W(DATA_W)) u_reg_a (
        .clk(clk), .rst(rst), .cap(a_cap), .d(a_bus_i), .q(reg_a));
    xcvr_capture_reg #(.W(DATA_W)) u_reg_b (
        .clk(clk), .rst(rst), .cap(b_cap), .d(b_bus_i), .q(reg_b));

    xcvr_dir_mux #(.W(DATA_W)) u_mux_ab (
        .sel(ab_src), .live(a_bus_i), .stored(reg_a), .y(to_b));
    xcvr_dir_mux #(.W(DATA_W)) u_mux_ba (
        .sel(ba_src), .live(b_bus_i), .stored(reg_b), .y(to_a));

    xcvr_bus_keeper #(.W(DATA_W)) u_keeper (
        .clk(clk), .rst(rst), .hold(drv.hold_loop),
        .a_bus(a_bus_i), .a_ext(a_ext_i),
        .b_bus(b_bus_i), .b_ext(b_ext_i),
        .hold_val(hold_val));

    always_comb begin
        if (drv.hold_loop) begin
            a_bus_o  = hold_val;
            b_bus_o  = hold_val;
            a_bus_oe = ~a_ext_i;
            b_bus_oe = ~b_ext_i;
        end else begin
            a_bus_o  = to_a;
            b_bus_o  = to_b;
            a_bus_oe = drv.drive_a;
            b_bus_oe = drv.drive_b;
        end
    end

    // R6
    isolate_chk: assert property (@(posedge clk) disable iff (rst)
        (!ab_drive && ba_drive_n) |-> (!a_bus_oe && !b_bus_oe));

    // R4
    b_enable_chk: assert property (@(posedge clk) disable iff (rst)
        (ab_drive && ab_use_reg) |-> b_bus_oe);

    // R10
    yield_a_chk: assert property (@(posedge clk) disable iff (rst)
        (ab_drive && !ba_drive_n && !ab_use_reg && !ba_use_reg && a_ext_i) |-> !a_bus_oe);
endmodule

// File: tb/test_regbus_xcvr.sv
module test_regbus_xcvr;
    logic       clk = 1'b0;
    logic       rst;
    logic       a_cap, b_cap, ab_drive, ba_drive_n, ab_use_reg, ba_use_reg;
    logic       a_ext_i, b_ext_i;
    logic [7:0] a_drv, b_drv;
    logic [7:0] a_bus_i, b_bus_i, a_bus_o, b_bus_o;
    logic       a_bus_oe, b_bus_oe;
    int         n_chk = 0;
    int         n_bad = 0;
    bit         done  = 1'b0;

    always #4 clk = ~clk;

    assign a_bus_i = a_bus_oe ? a_bus_o : (a_ext_i ? a_drv : 8'hzz);
    assign b_bus_i = b_bus_oe ? b_bus_o : (b_ext_i ? b_drv : 8'hzz);

    regbus_xcvr i_regbus_xcvr (
        .clk(clk), .rst(rst), .a_cap(a_cap), .b_cap(b_cap),
        .ab_drive(ab_drive), .ba_drive_n(ba_drive_n),
        .ab_use_reg(ab_use_reg), .ba_use_reg(ba_use_reg),
        .a_bus_i(a_bus_i), .a_ext_i(a_ext_i), .a_bus_o(a_bus_o), .a_bus_oe(a_bus_oe),
        .b_bus_i(b_bus_i), .b_ext_i(b_ext_i), .b_bus_o(b_bus_o), .b_bus_oe(b_bus_oe));

    task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic settle();
        #1;
    endtask

    task automatic set_mode(input logic abd, input logic bdn, input logic abr, input logic bar);
        ab_drive = abd; ba_drive_n = bdn; ab_use_reg = abr; ba_use_reg = bar;
    endtask

    task automatic t_reset();
        rst = 1'b1; a_cap = 0; b_cap = 0; a_ext_i = 0; b_ext_i = 0;
        a_drv = 0; b_drv = 0; set_mode(0, 1, 0, 0);
        step(); step();
        rst = 1'b0;
        set_mode(1, 0, 1, 1);
        settle();
        chk("R1 a stored after reset", a_bus_o, 8'h00);
        chk("R1 b stored after reset", b_bus_o, 8'h00);
        chk("R7 both enables", {6'b0, a_bus_oe, b_bus_oe}, 8'h03);
    endtask

    task automatic t_live_paths();
        @(negedge clk);
        set_mode(1, 1, 0, 0); a_ext_i = 1; a_drv = 8'h5A; b_ext_i = 0;
        settle();
        chk("R4 live A to B", b_bus_o, 8'h5A);
        chk("R4 b enable / R5 a released", {6'b0, a_bus_oe, b_bus_oe}, 8'h01);
        a_drv = 8'hC3;
        settle();
        chk("R4 live follows same cycle", b_bus_o, 8'hC3);
        @(negedge clk);
        a_ext_i = 0; set_mode(0, 0, 0, 0); b_ext_i = 1; b_drv = 8'h96;
        settle();
        chk("R5 live B to A", a_bus_o, 8'h96);
        chk("R5 a enable only", {6'b0, a_bus_oe, b_bus_oe}, 8'h02);
    endtask

    task automatic t_capture_isolation();
        @(negedge clk);
        set_mode(0, 1, 1, 1);
        a_ext_i = 1; a_drv = 8'h11; b_ext_i = 1; b_drv = 8'h22;
        a_cap = 1; b_cap = 1;
        settle();
        chk("R6 isolation no drive", {6'b0, a_bus_oe, b_bus_oe}, 8'h00);
        step();
        a_cap = 0; b_cap = 0;
        a_ext_i = 0; b_ext_i = 0; set_mode(1, 0, 1, 1);
        settle();
        chk("R3/R7 A side shows B reg", a_bus_o, 8'h22);
        chk("R3/R7 B side shows A reg", b_bus_o, 8'h11);
    endtask

    task automatic t_no_capture();
        @(negedge clk);
        set_mode(0, 1, 0, 0);
        a_ext_i = 1; a_drv = 8'h77; b_ext_i = 1; b_drv = 8'h88;
        step(); step(); step();
        a_ext_i = 0; b_ext_i = 0; set_mode(1, 0, 1, 1);
        settle();
        chk("R11 A reg kept", b_bus_o, 8'h11);
        chk("R11 B reg kept", a_bus_o, 8'h22);
    endtask

    task automatic t_store_driven();
        @(negedge clk);
        set_mode(1, 1, 0, 0); a_ext_i = 1; a_drv = 8'h3C; b_ext_i = 0;
        a_cap = 1; b_cap = 1;
        step();
        a_cap = 0; b_cap = 0;
        a_ext_i = 0; set_mode(1, 0, 1, 1);
        settle();
        chk("R8 B reg holds driven A data", a_bus_o, 8'h3C);
        chk("R8/R2 A reg loaded", b_bus_o, 8'h3C);
    endtask

    task automatic t_hold_loop();
        @(negedge clk);
        set_mode(1, 1, 0, 0); a_ext_i = 1; a_drv = 8'hE7; b_ext_i = 0;
        step();
        a_ext_i = 0; set_mode(1, 0, 0, 0);
        settle();
        chk("R9 hold drives both", {6'b0, a_bus_oe, b_bus_oe}, 8'h03);
        chk("R9 hold A value", a_bus_o, 8'hE7);
        step(); step();
        chk("R9 hold persists B", b_bus_o, 8'hE7);
        a_ext_i = 1; a_drv = 8'h4B;
        settle();
        chk("R10 A released under outside drive", {7'b0, a_bus_oe}, 8'h00);
        chk("R10 B follows outside A", b_bus_o, 8'h4B);
        step();
        a_ext_i = 0;
        settle();
        chk("R10 kept after A release", a_bus_o, 8'h4B);
        b_ext_i = 1; b_drv = 8'hD2;
        settle();
        chk("R10 A follows outside B", a_bus_o, 8'hD2);
        chk("R10 B released", {7'b0, b_bus_oe}, 8'h00);
        step();
        b_ext_i = 0;
        step();
        chk("R10 kept after B release", b_bus_o, 8'hD2);
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_live_paths();
        t_capture_isolation();
        t_no_capture();
        t_store_driven();
        t_hold_loop();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        #(8 * 20000);
        if (!done) begin
            done = 1'b1;
            n_chk++; n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule